// File: doc/BRIEF.md
# Keyed Configuration Index/Data Port

This block is the register front end of a peripheral chip's configuration space. A host reaches it through two byte-wide I/O addresses: an index port and a data port. After reset the space is locked. It opens only when a fixed four-byte entry key has been written to the index port. While it is open, a write to the index port selects a register, and the data port then reads or writes that register. A write of the exit command closes the space again.

The register space is split into two parts. Indices below 0x30 are global: a logical-device selector, a chip identifier, a revision nibble and the exit register. Indices from 0x30 upward form a per-device bank, and the selector decides which bank is visible. Each bank holds an activate bit, a 16-bit base address and a small window of auxiliary bytes. All bank contents are driven out continuously so that attached logic, such as a watchdog, can use them. Decoding of any host address other than the two ports is left to the surrounding chip.

Top module: `cfg_port`

## Requirements
- R1: After a synchronous active-low reset the space is locked (`cfg_open` = 0), `bus_rdata` is 0x00, the device selector is 0, and every activate bit, base address and auxiliary byte is 0.
- R2: While locked, a read of either port returns 0xFF, and a data-port write changes no register.
- R3: The space opens after the bytes 0x87, 0x01, 0x55, 0x55 are written to the index port (address 0x2E) in that order. The data port is at address 0x2F.
- R4: A byte that does not match the next expected key byte restarts matching. If that mismatching byte is 0x87, it counts as the first key byte.
- R5: While open, a data-port write of 0x02 with index 0x02 locks the space again. Opening it afterwards needs the full key once more.
- R6: Index 0x20 reads the high byte of the chip identifier and 0x21 reads the low byte. Index 0x22 reads the revision in bits 3:0, with bits 7:4 at zero.
- R7: Index 0x07 is a read/write device selector. Data-port writes at indices 0x30 and above reach only the bank that the selector names.
- R8: In each bank, index 0x30 bit 0 is the activate bit, 0x60/0x61 are the high/low bytes of the base address, and 0x70 upward is the auxiliary window. Each of these reads back and drives the matching output slice.
- R9: When the selector is at or above the number of banks, bank-range writes change nothing and bank-range reads return 0x00.
- R10: A read strobe on a port updates `bus_rdata` at that clock edge, which gives one cycle of latency. The value holds until the next read. A read of the index port while open returns the current index.
- R11: Unimplemented indices read 0x00, and writes to them have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | ADDR_W | Host I/O address |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_rd | input | 1 | Read strobe, one cycle per access |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Registered read data |
| cfg_open | output | 1 | High while the configuration space is unlocked |
| dev_active | output | NUM_LDN | Activate bit of each bank |
| dev_base | output | NUM_LDN*16 | Base address of each bank, bank g at bits g*16 upward |
| dev_aux | output | NUM_LDN*NUM_AUX*8 | Auxiliary bytes, bank g byte k at bits (g*NUM_AUX+k)*8 upward |

## Verification
A key matcher left in the wrong state can fail in two ways, and both show on `cfg_open` in the cycle after the fourth key byte. Either the port opens after a broken sequence, or it stays shut after a correct one that follows a stray 0x87. A wrong selector or bank decode puts a written value on the wrong bank's output slice one cycle after the data-port write. The bench therefore checks the untouched banks as well as the target bank. A stale index or a lost lock shows on the next read, one cycle after the strobe, as the wrong register value or as a value where 0xFF was due.

// File: rtl/cfgp_pkg.sv
// Shared constants for the keyed configuration port.
// Assumes an 8-bit register index space with the global part below 0x30.
package cfgp_pkg;

    localparam logic [7:0] IDX_EXIT    = 8'h02;
    localparam logic [7:0] IDX_LDN     = 8'h07;
    localparam logic [7:0] IDX_ID_HI   = 8'h20;
    localparam logic [7:0] IDX_ID_LO   = 8'h21;
    localparam logic [7:0] IDX_REV     = 8'h22;
    localparam logic [7:0] IDX_BANK0   = 8'h30;
    localparam logic [7:0] IDX_ACT     = 8'h30;
    localparam logic [7:0] IDX_BASE_HI = 8'h60;
    localparam logic [7:0] IDX_BASE_LO = 8'h61;
    localparam logic [7:0] IDX_AUX0    = 8'h70;
    localparam logic [7:0] EXIT_CMD    = 8'h02;
    localparam logic [7:0] LOCKED_RD   = 8'hFF;
    localparam int         KEY_LEN     = 4;

    // Entry key byte for match position n
    function automatic logic [7:0] key_byte(input logic [1:0] n);
        case (n)
            2'd0:    key_byte = 8'h87;
            2'd1:    key_byte = 8'h01;
            default: key_byte = 8'h55;
        endcase
    endfunction

endpackage

// File: rtl/cfgp_key_seq.sv
// Entry-key matcher and lock state.
// While locked it follows index-port writes against the four-byte key.
// A mismatch restarts matching; a mismatching first-key byte counts as
// position one. While open, only exit_req closes the space.
module cfgp_key_seq
    import cfgp_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       idx_wr,
    input  logic [7:0] wdata,
    input  logic       exit_req,
    output logic       unlocked
);

    localparam int POS_W = $clog2(KEY_LEN);

    logic [POS_W-1:0] match_q;
    logic             open_q;

    // Advance, restart or complete the key match; handle the exit command
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            match_q <= '0;
            open_q  <= 1'b0;
        end else if (open_q) begin
            if (exit_req) begin
                open_q  <= 1'b0;
                match_q <= '0;
            end
        end else if (idx_wr) begin
            if (wdata == key_byte(match_q)) begin
                if (match_q == POS_W'(KEY_LEN - 1)) begin
                    open_q  <= 1'b1;
                    match_q <= '0;
                end else begin
                    match_q <= match_q + 1'b1;
                end
            end else if (wdata == key_byte(2'd0)) begin
                match_q <= POS_W'(1);
            end else begin
                match_q <= '0;
            end
        end
    end

    assign unlocked = open_q;

endmodule

// File: rtl/cfgp_bank.sv
// One logical device's register bank: activate bit, 16-bit base address
// and NUM_AUX auxiliary bytes. Writes arrive already qualified by the
// caller (space open, bank selected, index in bank range).
module cfgp_bank
    import cfgp_pkg::*;
#(
    parameter int NUM_AUX = 4
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   wr_en,
    input  logic [7:0]             idx,
    input  logic [7:0]             wdata,
    output logic [7:0]             rd_val,
    output logic                   active,
    output logic [15:0]            base,
    output logic [NUM_AUX*8-1:0]   aux
);

    logic        act_q;
    logic [15:0] base_q;
    logic [7:0]  aux_q [NUM_AUX];
    logic [7:0]  aux_off;
    logic        aux_hit;

    // Offset of the index inside the auxiliary window
    always_comb begin
        aux_off = idx - IDX_AUX0;
        aux_hit = (idx >= IDX_AUX0) && (aux_off < 8'(NUM_AUX));
    end

    // Store the fixed bank registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            act_q  <= 1'b0;
            base_q <= '0;
        end else if (wr_en) begin
            if (idx == IDX_ACT)     act_q        <= wdata[0];
            if (idx == IDX_BASE_HI) base_q[15:8] <= wdata;
            if (idx == IDX_BASE_LO) base_q[7:0]  <= wdata;
        end
    end

    // Store the auxiliary window bytes
    always_ff @(posedge clk) begin
        for (int k = 0; k < NUM_AUX; k++) begin
            if (!rst_n)
                aux_q[k] <= '0;
            else if (wr_en && aux_hit && aux_off == 8'(k))
                aux_q[k] <= wdata;
        end
    end

    // Read back the register at the current index
    always_comb begin
        rd_val = 8'h00;
        if (idx == IDX_ACT)          rd_val = {7'b0, act_q};
        else if (idx == IDX_BASE_HI) rd_val = base_q[15:8];
        else if (idx == IDX_BASE_LO) rd_val = base_q[7:0];
        else if (aux_hit) begin
            for (int k = 0; k < NUM_AUX; k++)
                if (aux_off == 8'(k)) rd_val = aux_q[k];
        end
    end

    genvar gk;
    generate
        for (gk = 0; gk < NUM_AUX; gk++) begin : g_aux_out
            assign aux[gk*8 +: 8] = aux_q[gk];
        end
    endgenerate

    assign active = act_q;
    assign base   = base_q;

endmodule

// File: rtl/cfg_port.sv
// Keyed index/data configuration port: top level.
// Decodes the two host ports, keeps the index and device selector, holds
// one bank per logical device and registers read data. Assumes one-cycle
// strobes and that a read and a write never share a cycle.
module cfg_port
    import cfgp_pkg::*;
#(
    parameter int              ADDR_W   = 16,
    parameter logic [ADDR_W-1:0] IDX_PORT = 16'h002E,
    parameter logic [ADDR_W-1:0] DAT_PORT = 16'h002F,
    parameter int              NUM_LDN  = 8,
    parameter int              NUM_AUX  = 4,
    parameter logic [15:0]     CHIP_ID  = 16'h8A51,
    parameter logic [3:0]      CHIP_REV = 4'h3
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic [ADDR_W-1:0]             bus_addr,
    input  logic                          bus_wr,
    input  logic                          bus_rd,
    input  logic [7:0]                    bus_wdata,
    output logic [7:0]                    bus_rdata,
    output logic                          cfg_open,
    output logic [NUM_LDN-1:0]            dev_active,
    output logic [NUM_LDN*16-1:0]         dev_base,
    output logic [NUM_LDN*NUM_AUX*8-1:0]  dev_aux
);

    localparam int SEL_W = (NUM_LDN > 1) ? $clog2(NUM_LDN) : 1;

    logic       idx_sel, dat_sel;
    logic       idx_wr, dat_wr, exit_req, bank_wr, ldn_ok;
    logic [7:0] idx_q, ldn_q, glb_rd, cfg_rd;
    logic [7:0] bank_rd [NUM_LDN];

    // Port decode and write qualification
    always_comb begin
        idx_sel  = (bus_addr == IDX_PORT);
        dat_sel  = (bus_addr == DAT_PORT);
        idx_wr   = bus_wr && idx_sel;
        dat_wr   = bus_wr && dat_sel && cfg_open;
        exit_req = dat_wr && (idx_q == IDX_EXIT) && (bus_wdata == EXIT_CMD);
        ldn_ok   = (ldn_q < 8'(NUM_LDN));
        bank_wr  = dat_wr && (idx_q >= IDX_BANK0) && ldn_ok;
    end

    cfgp_key_seq u_key (
        .clk      (clk),
        .rst_n    (rst_n),
        .idx_wr   (idx_wr),
        .wdata    (bus_wdata),
        .exit_req (exit_req),
        .unlocked (cfg_open)
    );

    // Index register: loaded by index-port writes while open
    always_ff @(posedge clk) begin
        if (!rst_n)                idx_q <= '0;
        else if (cfg_open && idx_wr) idx_q <= bus_wdata;
    end

    // Logical device selector
    always_ff @(posedge clk) begin
        if (!rst_n)                             ldn_q <= '0;
        else if (dat_wr && idx_q == IDX_LDN)    ldn_q <= bus_wdata;
    end

    genvar gl;
    generate
        for (gl = 0; gl < NUM_LDN; gl++) begin : g_bank
            cfgp_bank #(.NUM_AUX(NUM_AUX)) u_bank (
                .clk    (clk),
                .rst_n  (rst_n),
                .wr_en  (bank_wr && ldn_q == 8'(gl)),
                .idx    (idx_q),
                .wdata  (bus_wdata),
                .rd_val (bank_rd[gl]),
                .active (dev_active[gl]),
                .base   (dev_base[gl*16 +: 16]),
                .aux    (dev_aux[gl*NUM_AUX*8 +: NUM_AUX*8])
            );
        end
    endgenerate

    // Global register readback
    always_comb begin
        case (idx_q)
            IDX_LDN:   glb_rd = ldn_q;
            IDX_ID_HI: glb_rd = CHIP_ID[15:8];
            IDX_ID_LO: glb_rd = CHIP_ID[7:0];
            IDX_REV:   glb_rd = {4'h0, CHIP_REV};
            default:   glb_rd = 8'h00;
        endcase
    end

    // Select global or banked readback
    always_comb begin
        if (idx_q < IDX_BANK0) cfg_rd = glb_rd;
        else if (ldn_ok)       cfg_rd = bank_rd[ldn_q[SEL_W-1:0]];
        else                   cfg_rd = 8'h00;
    end

    // Registered read data, held between reads
    always_ff @(posedge clk) begin
        if (!rst_n)
            bus_rdata <= 8'h00;
        else if (bus_rd && idx_sel)
            bus_rdata <= cfg_open ? idx_q : LOCKED_RD;
        else if (bus_rd && dat_sel)
            bus_rdata <= cfg_open ? cfg_rd : LOCKED_RD;
    end

endmodule

// File: rtl/cfg_port_chk.sv
// Property checker for cfg_port, attached by bind.
// Observes the host ports, the bank outputs and the index/selector state.
module cfg_port_chk #(
    parameter int              ADDR_W   = 16,
    parameter logic [ADDR_W-1:0] IDX_PORT = 16'h002E,
    parameter logic [ADDR_W-1:0] DAT_PORT = 16'h002F,
    parameter int              NUM_LDN  = 8,
    parameter int              NUM_AUX  = 4
) (
    input logic                          clk,
    input logic                          rst_n,
    input logic [ADDR_W-1:0]             bus_addr,
    input logic                          bus_wr,
    input logic                          bus_rd,
    input logic [7:0]                    bus_wdata,
    input logic [7:0]                    bus_rdata,
    input logic                          cfg_open,
    input logic [NUM_LDN-1:0]            dev_active,
    input logic [NUM_LDN*16-1:0]         dev_base,
    input logic [NUM_LDN*NUM_AUX*8-1:0]  dev_aux,
    input logic [7:0]                    idx_q,
    input logic [7:0]                    ldn_q
);

    AST_LOCKED_READ_FF: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && bus_addr == DAT_PORT && !cfg_open) |=> bus_rdata == 8'hFF); // R2

    AST_LOCKED_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_open |=> ($stable(dev_base) && $stable(dev_aux) && $stable(dev_active) && $stable(ldn_q))); // R2

    AST_OPEN_AFTER_KEY: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cfg_open) |-> $past(bus_wr && bus_addr == IDX_PORT && bus_wdata == 8'h55)); // R3

    AST_EXIT_LOCKS: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_open && bus_wr && bus_addr == DAT_PORT && idx_q == 8'h02 && bus_wdata == 8'h02) |=> !cfg_open); // R5

    AST_SEL_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_wr && bus_addr == DAT_PORT && idx_q == 8'h07) |=> $stable(ldn_q)); // R7

    AST_BAD_SEL_NO_BANK: assert property (@(posedge clk) disable iff (!rst_n)
        (ldn_q >= 8'(NUM_LDN)) |=> ($stable(dev_base) && $stable(dev_aux) && $stable(dev_active))); // R9

endmodule

bind cfg_port cfg_port_chk #(
    .ADDR_W   (ADDR_W),
    .IDX_PORT (IDX_PORT),
    .DAT_PORT (DAT_PORT),
    .NUM_LDN  (NUM_LDN),
    .NUM_AUX  (NUM_AUX)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .bus_addr   (bus_addr),
    .bus_wr     (bus_wr),
    .bus_rd     (bus_rd),
    .bus_wdata  (bus_wdata),
    .bus_rdata  (bus_rdata),
    .cfg_open   (cfg_open),
    .dev_active (dev_active),
    .dev_base   (dev_base),
    .dev_aux    (dev_aux),
    .idx_q      (idx_q),
    .ldn_q      (ldn_q)
);

// File: tb/cfg_port_tb.sv
// Scoreboard bench: read tasks queue the expected byte, a monitor pops it
// one cycle after the strobe and compares with bus_rdata.
module cfg_port_tb;

    localparam int NUM_LDN = 8;
    localparam int NUM_AUX = 4;
    localparam logic [15:0] IDXP = 16'h002E;
    localparam logic [15:0] DATP = 16'h002F;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] bus_addr = '0;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic [7:0]  bus_wdata = '0;
    logic [7:0]  bus_rdata;
    logic        cfg_open;
    logic [NUM_LDN-1:0]           dev_active;
    logic [NUM_LDN*16-1:0]        dev_base;
    logic [NUM_LDN*NUM_AUX*8-1:0] dev_aux;

    int checks = 0;
    int errors = 0;
    logic rd_seen = 1'b0;
    logic [7:0] q_exp [$];
    string      q_req [$];

    always #2.5 clk = ~clk;

    cfg_port u_dut (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .cfg_open(cfg_open), .dev_active(dev_active), .dev_base(dev_base),
        .dev_aux(dev_aux)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic [15:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic bus_read(input logic [15:0] a, input logic [7:0] exp, input string req);
        q_exp.push_back(exp);
        q_req.push_back(req);
        @(negedge clk);
        bus_addr = a; bus_rd = 1'b1;
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic reg_write(input logic [7:0] idx, input logic [7:0] d);
        bus_write(IDXP, idx);
        bus_write(DATP, d);
    endtask

    task automatic reg_read(input logic [7:0] idx, input logic [7:0] exp, input string req);
        bus_write(IDXP, idx);
        bus_read(DATP, exp, req);
    endtask

    task automatic send_key();
        bus_write(IDXP, 8'h87); bus_write(IDXP, 8'h01);
        bus_write(IDXP, 8'h55); bus_write(IDXP, 8'h55);
    endtask

    // Note a read strobe taken at the clock edge
    always @(posedge clk) rd_seen <= bus_rd;

    // Monitor: compare the registered read data with the queued expectation
    always @(negedge clk) begin
        if (rd_seen) begin
            if (q_exp.size() == 0) begin
                checks++; errors++;
                $display("FAIL R10: unexpected read result %h, expected none", bus_rdata);
            end else begin
                chk(q_req.pop_front(), 32'(bus_rdata), 32'(q_exp.pop_front()));
            end
        end
    end

    // Watchdog
    initial begin
        repeat (100000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1 open", 32'(cfg_open), 0);
        chk("R1 rdata", 32'(bus_rdata), 0);
        chk("R1 base", 32'(|dev_base), 0);
        chk("R1 aux", 32'(|dev_aux), 0);
        // R2 locked behaviour
        bus_read(DATP, 8'hFF, "R2 locked data read");
        bus_read(IDXP, 8'hFF, "R2 locked index read");
        bus_write(DATP, 8'h02);
        chk("R2 locked write", 32'(|dev_base | |dev_active), 0);
        // R4 broken key stays locked
        bus_write(IDXP, 8'h87); bus_write(IDXP, 8'h01);
        bus_write(IDXP, 8'h55); bus_write(IDXP, 8'h12);
        bus_write(IDXP, 8'h55);
        chk("R4 broken key", 32'(cfg_open), 0);
        // R4 stray 0x87 restarts as first byte
        bus_write(IDXP, 8'h87); bus_write(IDXP, 8'h01); bus_write(IDXP, 8'h87);
        bus_write(IDXP, 8'h01); bus_write(IDXP, 8'h55); bus_write(IDXP, 8'h55);
        chk("R4 restart on 0x87", 32'(cfg_open), 1);
        // R6 identification
        reg_read(8'h20, 8'h8A, "R6 id high");
        reg_read(8'h21, 8'h51, "R6 id low");
        reg_read(8'h22, 8'h03, "R6 revision");
        bus_read(IDXP, 8'h22, "R10 index read");
        bus_read(DATP, 8'h03, "R10 repeat read");
        // R7/R8 bank 3
        reg_write(8'h07, 8'h03);
        reg_read(8'h07, 8'h03, "R7 selector readback");
        reg_write(8'h30, 8'hFF);
        reg_write(8'h60, 8'h12);
        reg_write(8'h61, 8'h34);
        reg_write(8'h71, 8'hA5);
        chk("R8 active", 32'(dev_active), 32'h08);
        chk("R8 base", 32'(dev_base[3*16 +: 16]), 32'h1234);
        chk("R8 aux", 32'(dev_aux[(3*NUM_AUX+1)*8 +: 8]), 32'hA5);
        reg_read(8'h30, 8'h01, "R8 active readback");
        reg_read(8'h61, 8'h34, "R8 base low readback");
        reg_read(8'h71, 8'hA5, "R8 aux readback");
        // R7 other bank isolated
        reg_write(8'h07, 8'h05);
        reg_write(8'h60, 8'hBE);
        reg_read(8'h60, 8'hBE, "R7 bank5 readback");
        reg_read(8'h61, 8'h00, "R7 bank5 low clear");
        chk("R7 bank3 kept", 32'(dev_base[3*16 +: 16]), 32'h1234);
        chk("R7 bank5 base", 32'(dev_base[5*16 +: 16]), 32'hBE00);
        // R9 selector out of range
        reg_write(8'h07, 8'h20);
        reg_write(8'h60, 8'h77);
        reg_read(8'h60, 8'h00, "R9 out-of-range read");
        chk("R9 bank3 base", 32'(dev_base[3*16 +: 16]), 32'h1234);
        chk("R9 bank5 base", 32'(dev_base[5*16 +: 16]), 32'hBE00);
        // R11 unimplemented indices
        reg_write(8'h07, 8'h05);
        reg_write(8'h45, 8'h9C);
        reg_read(8'h45, 8'h00, "R11 bank gap");
        reg_write(8'h10, 8'h9C);
        reg_read(8'h10, 8'h00, "R11 global gap");
        reg_read(8'h74, 8'h00, "R11 past aux window");
        chk("R11 no side effect", 32'(dev_base[5*16 +: 16]), 32'hBE00);
        // R5 exit
        reg_write(8'h02, 8'h02);
        chk("R5 exit", 32'(cfg_open), 0);
        bus_read(DATP, 8'hFF, "R5 locked after exit");
        bus_write(IDXP, 8'h60);
        bus_write(DATP, 8'h11);
        chk("R5 write after exit", 32'(dev_base[5*16 +: 16]), 32'hBE00);
        // R3 clean key reopens
        send_key();
        chk("R3 open", 32'(cfg_open), 1);
        reg_read(8'h07, 8'h05, "R3 selector kept");
        // R1 second reset clears banks
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); rst_n = 1'b1;
        @(negedge clk);
        chk("R1 re-reset open", 32'(cfg_open), 0);
        chk("R1 re-reset base", 32'(|dev_base), 0);
        chk("R1 re-reset active", 32'(dev_active), 0);
        @(negedge clk);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule